// File: doc/BRIEF.md
# Extended Full-Period XNOR Shift Counter

This block counts with a four-stage shift register instead of an adder. The first stage takes the XNOR of the last two stages. That feedback alone would never reach the all-ones value. A small decode of the low three bits inverts the feedback where needed, so all-ones is spliced into the cycle. The counter therefore passes through all sixteen codes once per period, in a fixed scrambled order. The next-state path is one XNOR plus a three-input AND and one XOR, which is much shallower than a binary carry chain.

A user keeps the enable high to advance one step per clock. The user watches the state, or uses the terminal strobe to mark the end of each period. The end value is a parameter. The reset input is asynchronous and active low. Inside the block, its release is synchronised to the clock.

Top module: `xshift_fullcycle_ctr`

## Requirements
- R1: While `rst_n` is low, `state` is 4'h0 and `term` is 0, with no clock edge needed. After `rst_n` rises, the first two rising clock edges leave `state` at 4'h0. The third edge is the first that can advance it.
- R2: When `en` is low and reset is inactive, `state` keeps its value across the clock edge.
- R3: `state[0]` is the first stage, and each enabled edge shifts `state[2:0]` into `state[3:1]`. The new `state[0]` is the XNOR of `state[3]` and `state[2]`. This bit is inverted when `state[2:0]` is 3'b111.
- R4: From 4'h0, the enabled sequence in hex is 0,1,3,7,F,E,D,B,6,C,9,2,5,A,4,8, and then 0 again.
- R5: The all-ones value 4'hF is entered only from 4'h7. An enabled edge moves it to 4'hE and never leaves it at 4'hF.
- R6: Sixteen enabled edges from any state return the counter to that state. Each of the sixteen values appears exactly once in between.
- R7: `term` is high in exactly the cycles where `en` is high and `state` equals the parameter `END_STATE` (default 4'h8). The strobe is combinational in that same cycle.
- R8: With `en` held high, `term` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| en | input | 1 | Count enable, one step per enabled edge |
| state | output | 4 | Current counter value, bit 0 is the first stage |
| term | output | 1 | End-of-period strobe |

## Verification
Two functions can meet in one cycle: detecting the end value and holding on a low enable. When the state sits at the end value, the bench drops `en` for a few cycles. It expects `term` to stay low and `state` to stay put. It then raises `en` and expects one strobe followed by the wrap to 4'h0. A second case lets the splice decode at 4'h7 coincide with a held enable. The bench checks that the counter neither enters nor skips 4'hF until `en` returns.

// File: rtl/xshift_pkg.sv
package xshift_pkg;
  localparam int unsigned XS_WIDTH = 4;
  typedef logic [XS_WIDTH-1:0] xs_word_t;
  localparam xs_word_t XS_ZERO = '0;
endpackage

// File: rtl/xshift_rst_sync.sv
module xshift_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xshift_next.sv
module xshift_next #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned TAP_HI = 4,
  parameter int unsigned TAP_LO = 3
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  localparam int unsigned LOW_BITS = WIDTH - 1;

  logic fb_plain;
  logic splice;
  logic fb;

  always_comb begin
    fb_plain = ~(cur[TAP_HI-1] ^ cur[TAP_LO-1]);
    splice   = &cur[LOW_BITS-1:0];
    fb       = fb_plain ^ splice;
  end

  assign nxt[0] = fb;
  for (genvar g = 1; g < WIDTH; g++) begin : g_shift
    assign nxt[g] = cur[g-1];
  end
endmodule

// File: rtl/xshift_term_dec.sv
module xshift_term_dec #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] END_STATE = '0
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en,
  output logic             hit
);
  always_comb begin
    hit = en && (cur == END_STATE);
  end
endmodule

// File: rtl/xshift_fullcycle_ctr.sv
module xshift_fullcycle_ctr
  import xshift_pkg::*;
#(
  parameter logic [XS_WIDTH-1:0] END_STATE = 4'h8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  output logic [XS_WIDTH-1:0] state,
  output logic                term
);
  localparam int unsigned W = XS_WIDTH;
  localparam xs_word_t ONES = '1;

  logic     rst_q_n;
  xs_word_t cnt_q;
  xs_word_t step;
  xs_word_t cnt_d;

  xshift_rst_sync #(.STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  xshift_next #(.WIDTH(W), .TAP_HI(W), .TAP_LO(W-1)) u_next (
    .cur (cnt_q),
    .nxt (step)
  );

  xshift_term_dec #(.WIDTH(W), .END_STATE(END_STATE)) u_term (
    .cur (cnt_q),
    .en  (en),
    .hit (term)
  );

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = step;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) cnt_q <= XS_ZERO;
    else          cnt_q <= cnt_d;
  end

  assign state = cnt_q;

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_q_n |-> (state == XS_ZERO) && !term); // R1
  AST_HOLD_LOW_EN: assert property (@(posedge clk) disable iff (!rst_q_n) !en |=> $stable(state)); // R2
  AST_ALWAYS_MOVES: assert property (@(posedge clk) disable iff (!rst_q_n) en |=> state != $past(state)); // R3
  AST_ONES_ENTRY: assert property (@(posedge clk) disable iff (!rst_q_n) (en && state != 4'h7 && state != ONES) |=> state != ONES); // R5
  AST_ONES_EXIT: assert property (@(posedge clk) disable iff (!rst_q_n) (en && state == ONES) |=> state == 4'hE); // R5
  AST_TERM_MATCH: assert property (@(posedge clk) disable iff (!rst_q_n) term |-> en && state == END_STATE); // R7
  AST_TERM_SINGLE: assert property (@(posedge clk) disable iff (!rst_q_n) (term && en) |=> !(term && $past(en) && en)); // R8
endmodule

// File: tb/sim_xshift_fullcycle_ctr.sv
module sim_xshift_fullcycle_ctr;
  localparam int PER = 10;
  localparam logic [3:0] ENDV = 4'h8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0] state;
  logic term;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] seq [16];
  int idx = 0;
  logic [3:0] exp_q [$];
  string tag_q [$];

  always #(PER/2) clk = ~clk;

  xshift_fullcycle_ctr #(.END_STATE(ENDV)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .state(state), .term(term)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: set enable between edges, check the strobe, queue the expected state.
  task automatic step(input logic e, input string req);
    en = e;
    #1;
    chk("R7 term", {3'b0, term}, {3'b0, e && (seq[idx] == ENDV)});
    if (e) idx = (idx + 1) % 16;
    exp_q.push_back(seq[idx]);
    tag_q.push_back(req);
    @(negedge clk);
  endtask

  // Monitor: pops one expected item after each rising edge.
  always @(posedge clk) begin
    #(PER/4);
    if (exp_q.size() > 0) chk(tag_q.pop_front(), state, exp_q.pop_front());
  end

  initial begin
    #(PER*200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    seq = '{4'h0,4'h1,4'h3,4'h7,4'hF,4'hE,4'hD,4'hB,4'h6,4'hC,4'h9,4'h2,4'h5,4'hA,4'h4,4'h8};
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 reset state", state, 4'h0);
    chk("R1 reset term", {3'b0, term}, 4'h0);
    // R1 release timing with enable already high
    en = 1'b1;
    rst_n = 1'b1;
    @(posedge clk); #(PER/4); chk("R1 release edge1", state, 4'h0);
    @(posedge clk); #(PER/4); chk("R1 release edge2", state, 4'h0);
    @(posedge clk); #(PER/4); chk("R1 release edge3", state, 4'h1);
    // re-enter reset asynchronously mid-count
    @(negedge clk); #2; rst_n = 1'b0; #1;
    chk("R1 async clear", state, 4'h0);
    en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idx = 0;
    // R4 R6: full period from zero, each value once
    for (int i = 0; i < 16; i++) step(1'b1, "R4 sequence");
    chk("R6 back to start", seq[idx], 4'h0);
    // R2 hold
    for (int i = 0; i < 3; i++) step(1'b0, "R2 hold");
    // R5 hold at 4'h7 with splice pending
    for (int i = 0; i < 3; i++) step(1'b1, "R3 step");
    for (int i = 0; i < 3; i++) step(1'b0, "R5 hold at 7");
    step(1'b1, "R5 enter F");
    step(1'b0, "R2 hold at F");
    step(1'b1, "R5 exit to E");
    // run to end value, then hold there: no strobe while held (R7)
    while (seq[idx] != ENDV) step(1'b1, "R4 run");
    for (int i = 0; i < 4; i++) step(1'b0, "R7 hold at end");
    step(1'b1, "R7 strobe and wrap");
    // R8 two full periods with enable high, alternating patterns
    for (int i = 0; i < 32; i++) step(1'b1, "R8 long run");
    for (int i = 0; i < 20; i++) step(i % 3 != 0, "R6 gapped");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule